// File: doc/BRIEF.md
# Watchdog Timer with Selectable Tick Source and Power-of-Two Prescaler

This block guards a processor against runaway code. A counter advances on ticks from one of two sources, chosen by a static input. One source is a slow subsystem tick that keeps running while the processor is halted. It first passes through a pre-divider of either 2^PRE_LOG2 or 2^(PRE_LOG2+1) raw ticks. The other source is an instruction-rate tick at one quarter of the system clock, which arrives as a single-cycle enable. The selected tick goes through a fixed 2^BASE_LOG2 divider (256 by default) and then a prescaler of 2^code. The code is the low three bits of an 8-bit control byte whose other five bits are free flags for software.

Firmware must pulse `wd_clear` before the counter runs out. When the counter overflows while the processor runs, the block raises a one-cycle `rst_req` toward the reset controller. When it overflows during halt on the subsystem source, it raises a one-cycle `wake_pulse` instead. Both cases set the sticky `to_flag`. A static disable input turns the whole watchdog into a no-op.

A four-state mode machine sets whether ticks count. `ST_RUN` counts ticks and turns an overflow into a reset request. `ST_HOLD` is a halt on the instruction source, and the count is frozen. `ST_SLEEP` is a halt on the subsystem source: counting continues and an overflow becomes a wake-up. `ST_OFF` is disabled and absorbing. The named transitions are:
- T_DISABLE: from any state to `ST_OFF` when `cfg_off` is set.
- T_HALT_FREEZE: `ST_RUN` to `ST_HOLD` on halt with the instruction source.
- T_HALT_SLEEP: `ST_RUN` to `ST_SLEEP` on halt with the subsystem source.
- T_RESUME: `ST_HOLD` or `ST_SLEEP` back to `ST_RUN` when halt drops.

Reset enters `ST_RUN`.

Top module: `wdt_prescaled`

## Requirements
- R1: While `rst_n` is low, `reg_rdata` reads 8'h07 (prescale code 7, flags zero), and `rst_req`, `wake_pulse` and `to_flag` are 0.
- R2: With the instruction source (`cfg_src_sub`=0), `rst_req` goes high for exactly one cycle on the cycle after the edge that takes the 2^(BASE_LOG2+code)-th counted `instr_tick` since the last clear or overflow. After that the count restarts from zero.
- R3: The prescale code is `reg_rdata[2:0]`. Code k multiplies the period by 2^k, for k = 0 to 7.
- R4: Bits 7:3 of the control byte read back as written, one cycle after `reg_we`, and have no effect on the time-out period.
- R5: With the subsystem source, one counted tick is produced per 2 raw `sub_tick` pulses when `cfg_sub_long`=0 and per 4 when it is 1. These are the bench values of 2^PRE_LOG2 and 2^(PRE_LOG2+1). The pre-divider is cleared only by `rst_n`.
- R6: With the instruction source, while `halt` is high the count does not advance and no overflow occurs. `halt` takes effect from the cycle after it is sampled.
- R7: With the subsystem source and `halt` high, counting continues. An overflow gives a one-cycle `wake_pulse`, no `rst_req`, and sets `to_flag`.
- R8: A `wd_clear` pulse restarts the count from zero. A clear in the same cycle as a counted tick wins, so that tick is lost.
- R9: `to_flag` is set by every overflow and stays set until `to_clear` or `rst_n`. An overflow in the same cycle as `to_clear` leaves it set.
- R10: With `cfg_off`=1 there is never an `rst_req` or `wake_pulse`, `wd_clear` has no effect, and `to_flag` stays 0.
- R11: A new prescale code is used from the next counted tick. The running count is not reset by the write.
- R12: The tick input of the source not selected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_src_sub | input | 1 | Static: 1 = subsystem tick source, 0 = instruction tick |
| cfg_sub_long | input | 1 | Static: selects the longer subsystem pre-division |
| cfg_off | input | 1 | Static: disables the watchdog |
| sub_tick | input | 1 | Raw subsystem tick, one-cycle enable |
| instr_tick | input | 1 | Instruction-rate tick, one-cycle enable |
| halt | input | 1 | Processor halted |
| wd_clear | input | 1 | Restart the watchdog count |
| to_clear | input | 1 | Clear the time-out flag |
| reg_we | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read data |
| rst_req | output | 1 | One-cycle chip reset request |
| wake_pulse | output | 1 | One-cycle wake-up request |
| to_flag | output | 1 | Sticky time-out status |

## Verification
Every overflow result (`rst_req`, `wake_pulse`, and the new `to_flag`) appears one cycle after the edge that takes the deciding tick, because the outputs are registered. A control write is visible on `reg_rdata` one cycle later. A change on `halt` reaches the mode register at the next edge, so the bench leaves one tick-free cycle after each halt change. The driver stamps each expected item with the cycle-counter value at which it becomes due, one edge after the stimulus. The monitor compares only items whose stamp equals the current count, sampling on the falling edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CTRL_W = 8;
    localparam int CODE_W = 3;
    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h07;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_SLEEP = 2'd3
    } wdt_state_e;

endpackage

// File: rtl/wdt_prediv.sv
module wdt_prediv #(
    parameter int PRE_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick,
    input  logic long_sel,
    output logic pre_tick
);
    logic [PRE_LOG2:0] pc_q;
    logic              at_last;

    assign at_last  = long_sel ? (&pc_q) : (&pc_q[PRE_LOG2-1:0]);
    assign pre_tick = sub_tick & at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (sub_tick) begin
            pc_q <= at_last ? '0 : pc_q + 1'b1;
        end
    end

    // short mode never reaches the upper half of the counter
    assert_short_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !long_sel |-> !pc_q[PRE_LOG2]);

    // pre-divider only moves on raw ticks
    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_tick |=> $stable(pc_q));
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg import wdt_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTRL_RST;
        end else if (we) begin
            q <= wdata;
        end
    end

    assert_write_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(wdata));

    assert_no_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/wdt_engine.sv
module wdt_engine import wdt_pkg::*; #(
    parameter int BASE_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_off,
    input  logic              cfg_src_sub,
    input  logic              halt,
    input  logic              pre_tick,
    input  logic              instr_tick,
    input  logic              wd_clear,
    input  logic              to_clear,
    input  logic [CODE_W-1:0] code,
    output logic              rst_req,
    output logic              wake_pulse,
    output logic              to_flag
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int CNT_W    = BASE_LOG2 + CODE_MAX;

    wdt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] span_mask;
    logic             sel_tick, clr_eff, count_en, ovf;

    // mode machine: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (cfg_off)   st_d = ST_OFF;
                else if (halt) st_d = cfg_src_sub ? ST_SLEEP : ST_HOLD;
            end
            ST_HOLD, ST_SLEEP: begin
                if (cfg_off)    st_d = ST_OFF;
                else if (!halt) st_d = ST_RUN;
            end
            ST_OFF: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // bits of the count that span the current period
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            span_mask[i] = (i < BASE_LOG2 + int'(code));
        end
    end

    assign sel_tick = cfg_src_sub ? pre_tick : instr_tick;
    assign clr_eff  = wd_clear && (st_q != ST_OFF);
    assign count_en = sel_tick && !clr_eff && ((st_q == ST_RUN) || (st_q == ST_SLEEP));
    assign ovf      = count_en && (&(cnt_q | ~span_mask));

    // outputs and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rst_req    <= 1'b0;
            wake_pulse <= 1'b0;
            to_flag    <= 1'b0;
        end else begin
            rst_req    <= ovf && (st_q == ST_RUN);
            wake_pulse <= ovf && (st_q == ST_SLEEP);
            if (clr_eff || ovf) cnt_q <= '0;
            else if (count_en)  cnt_q <= cnt_q + 1'b1;
            if (ovf)            to_flag <= 1'b1;
            else if (to_clear)  to_flag <= 1'b0;
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_freeze_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !wd_clear) |=> $stable(cnt_q));

    assert_wake_from_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(st_q) == ST_SLEEP));

    assert_req_wake_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_pulse));

    assert_flag_with_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_pulse) |-> to_flag);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !to_clear) |=> to_flag);

    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |=> (!rst_req && !wake_pulse));
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled import wdt_pkg::*; #(
    parameter int BASE_LOG2 = 8,
    parameter int PRE_LOG2  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_src_sub,
    input  logic              cfg_sub_long,
    input  logic              cfg_off,
    input  logic              sub_tick,
    input  logic              instr_tick,
    input  logic              halt,
    input  logic              wd_clear,
    input  logic              to_clear,
    input  logic              reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              rst_req,
    output logic              wake_pulse,
    output logic              to_flag
);
    logic              pre_tick;
    logic [CTRL_W-1:0] ctrl_q;

    wdt_prediv #(.PRE_LOG2(PRE_LOG2)) prediv_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_tick (sub_tick),
        .long_sel (cfg_sub_long),
        .pre_tick (pre_tick)
    );

    wdt_ctrl_reg ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .q     (ctrl_q)
    );

    wdt_engine #(.BASE_LOG2(BASE_LOG2)) engine_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_off     (cfg_off),
        .cfg_src_sub (cfg_src_sub),
        .halt        (halt),
        .pre_tick    (pre_tick),
        .instr_tick  (instr_tick),
        .wd_clear    (wd_clear),
        .to_clear    (to_clear),
        .code        (ctrl_q[CODE_W-1:0]),
        .rst_req     (rst_req),
        .wake_pulse  (wake_pulse),
        .to_flag     (to_flag)
    );

    assign reg_rdata = ctrl_q;
endmodule

// File: tb/wdt_prescaled_tb.sv
module wdt_prescaled_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int B  = 2;
    localparam int PL = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_src_sub = 1'b0, cfg_sub_long = 1'b0, cfg_off = 1'b0;
    logic       sub_tick = 1'b0, instr_tick = 1'b0, halt = 1'b0;
    logic       wd_clear = 1'b0, to_clear = 1'b0, reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rst_req, wake_pulse, to_flag;

    wdt_prescaled #(.BASE_LOG2(B), .PRE_LOG2(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_src_sub(cfg_src_sub), .cfg_sub_long(cfg_sub_long),
        .cfg_off(cfg_off), .sub_tick(sub_tick), .instr_tick(instr_tick), .halt(halt),
        .wd_clear(wd_clear), .to_clear(to_clear), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rst_req(rst_req), .wake_pulse(wake_pulse), .to_flag(to_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic  r;
        logic  w;
        logic  t;
        int    due;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int cyc = 0;
    int chk_d = 0, fail_d = 0;
    int chk_m = 0, fail_m = 0;

    // bench model state
    int   mcnt, pre_m, code_m;
    logic to_m, halt_m, off_m, src_m, lng_m;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops and compares items that are due
    always @(negedge clk) begin : monitor
        exp_item_t e;
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            e = sb_q.pop_front();
            chk_m++;
            if ({rst_req, wake_pulse, to_flag} !== {e.r, e.w, e.t}) begin
                fail_m++;
                $display("FAIL %s: req/wake/to actual=%b%b%b expected=%b%b%b",
                         e.tag, rst_req, wake_pulse, to_flag, e.r, e.w, e.t);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        chk_d++;
        if (act !== exp) begin
            fail_d++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic step(input logic it_i, input logic st_i, input logic wc_i,
                        input logic tc_i, input string tag);
        exp_item_t e;
        logic sel, clr, ok, ovf;
        int   m, plen;
        @(negedge clk);
        instr_tick = it_i; sub_tick = st_i; wd_clear = wc_i; to_clear = tc_i; reg_we = 1'b0;
        plen = lng_m ? (1 << (PL + 1)) : (1 << PL);
        sel  = 1'b0;
        if (src_m) begin
            if (st_i) begin
                if (pre_m == plen - 1) begin sel = 1'b1; pre_m = 0; end
                else pre_m++;
            end
        end else begin
            sel = it_i;
        end
        clr = wc_i && !off_m;
        ok  = !off_m && !(halt_m && !src_m) && !clr;
        m   = 1 << (B + code_m);
        if (clr) mcnt = 0;
        ovf = sel && ok && ((mcnt % m) == m - 1);
        if (ovf)            mcnt = 0;
        else if (sel && ok) mcnt++;
        if (ovf)       to_m = 1'b1;
        else if (tc_i) to_m = 1'b0;
        e.r = ovf && !halt_m;
        e.w = ovf && halt_m;
        e.t = to_m;
        e.due = cyc + 1;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic run(input int n, input logic it_i, input logic st_i, input string tag);
        for (int i = 0; i < n; i++) step(it_i, st_i, 1'b0, 1'b0, tag);
    endtask

    task automatic wr_ctrl(input logic [7:0] d, input string tag);
        @(negedge clk);
        instr_tick = 1'b0; sub_tick = 1'b0; wd_clear = 1'b0; to_clear = 1'b0;
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        chk(reg_rdata, d, tag);
        code_m = int'(d[2:0]);
    endtask

    task automatic set_halt(input logic v, input string tag);
        halt = v;
        step(1'b0, 1'b0, 1'b0, 1'b0, tag);
        halt_m = v;
    endtask

    task automatic do_reset(input logic off_i, input logic src_i, input logic lng_i);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        instr_tick = 1'b0; sub_tick = 1'b0; wd_clear = 1'b0; to_clear = 1'b0;
        reg_we = 1'b0; halt = 1'b0;
        cfg_off = off_i; cfg_src_sub = src_i; cfg_sub_long = lng_i;
        mcnt = 0; pre_m = 0; code_m = 7; to_m = 1'b0; halt_m = 1'b0;
        off_m = off_i; src_m = src_i; lng_m = lng_i;
        @(negedge clk);
        chk(reg_rdata, 8'h07, "R1 control byte in reset");
        chk({5'b0, rst_req, wake_pulse, to_flag}, 8'h00, "R1 outputs in reset");
        @(negedge clk);
        rst_n = 1'b1;
        run(3, 1'b0, 1'b0, "R1 idle after reset");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", chk_d + chk_m - fail_d - fail_m - 1, chk_d + chk_m + 1);
        $finish;
    end

    initial begin : main
        // instruction source: base period and repeat
        do_reset(1'b0, 1'b0, 1'b0);
        wr_ctrl(8'h00, "R3 write code 0");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(12, 1'b1, 1'b0, "R2 code 0 periodic");
        run(8, 1'b0, 1'b1, "R12 sub ticks ignored");
        run(4, 1'b1, 1'b0, "R12 count unchanged");
        // prescale code 3
        wr_ctrl(8'h03, "R3 write code 3");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(40, 1'b1, 1'b0, "R3 code 3 period");
        // flag bits have no effect
        wr_ctrl(8'hF9, "R4 flags readback");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(16, 1'b1, 1'b0, "R4 flags ignored");
        // time-out flag
        step(1'b0, 1'b0, 1'b0, 1'b1, "R9 to_clear");
        run(3, 1'b0, 1'b0, "R9 flag stays low");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(7, 1'b1, 1'b0, "R9 counting");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R9 set beats clear");
        // clear behaviour
        wr_ctrl(8'h01, "R3 write code 1");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(5, 1'b1, 1'b0, "R8 partial count");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear mid count");
        run(6, 1'b1, 1'b0, "R8 restart");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R8 clear wins over tick");
        run(9, 1'b1, 1'b0, "R8 period after clear");
        // halt on instruction source
        wr_ctrl(8'h00, "R3 write code 0");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(2, 1'b1, 1'b0, "R6 before halt");
        set_halt(1'b1, "R6 halt settle");
        run(10, 1'b1, 1'b0, "R6 frozen in halt");
        set_halt(1'b0, "R6 resume settle");
        run(2, 1'b1, 1'b0, "R6 resume continues");
        // prescale change mid count
        wr_ctrl(8'h02, "R11 write code 2");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(5, 1'b1, 1'b0, "R11 count under code 2");
        wr_ctrl(8'h00, "R11 write code 0");
        run(3, 1'b1, 1'b0, "R11 new code at next count");
        // subsystem source, short pre-division
        do_reset(1'b0, 1'b1, 1'b0);
        wr_ctrl(8'h00, "R3 write code 0");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(8, 1'b0, 1'b1, "R5 short pre-divide");
        run(5, 1'b1, 1'b0, "R12 instr ticks ignored");
        // subsystem source, long pre-division
        do_reset(1'b0, 1'b1, 1'b1);
        wr_ctrl(8'h00, "R3 write code 0");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8 clear");
        run(16, 1'b0, 1'b1, "R5 long pre-divide");
        // halt on subsystem source
        set_halt(1'b1, "R7 halt settle");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7 to_clear");
        run(16, 1'b0, 1'b1, "R7 wake in halt");
        set_halt(1'b0, "R7 resume settle");
        // disabled
        do_reset(1'b1, 1'b0, 1'b0);
        wr_ctrl(8'h00, "R10 write code 0");
        run(20, 1'b1, 1'b0, "R10 no overflow");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R10 clear ignored");
        run(6, 1'b1, 1'b0, "R10 still quiet");
        run(3, 1'b0, 1'b0, "drain");
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", chk_d + chk_m - fail_d - fail_m, chk_d + chk_m);
        $finish;
    end
endmodule